// File: doc/BRIEF.md
# Program Fetch Bus Sequencer

This block runs the bus side of an 8-bit microcontroller's instruction and external-data traffic. It picks the address of each code fetch from one of three sources: a program counter it keeps itself, a jump target, or an interrupt vector index. It then sends the fetch either to an internal program ROM port or out over a multiplexed external bus. On the external bus, one 8-bit port carries the low address byte and then the data byte. A second port carries the high address byte. An address-latch strobe, a program-store strobe and read/write strobes frame each transfer.

Routing depends on two things: a strap input and a parameterised internal ROM size. With the strap low, every fetch goes to the external bus. With the strap high, only addresses at or above the ROM size go out. The program-store strobe is driven only for external code fetches.

External data moves share the same bus. They use either an 8-bit address, which leaves the high port released for general I/O, or a 16-bit address, which drives the high port. A fetch request and a data request that arrive in the same cycle are handled one after the other, with the fetch first.

Top module: `prog_bus_seq`

## Requirements
- R1: After reset, the bus is idle: `psen_n`, `rd_n` and `wr_n` are 1, `ale`, `p0_oe`, `p2_oe` and `rom_en` are 0, and `fetch_ready` is 1. The first sequential fetch uses address 0x0000.
- R2: With `ext_strap` = 0, every fetch goes to the external bus (`fetch_ext` = 1), whatever its address.
- R3: With `ext_strap` = 1 and an address below `ROM_BYTES` (default 0x1000), the fetch uses the ROM port. `rom_en` is high for one cycle, `psen_n` stays 1 for the whole fetch, the ROM answers one cycle after `rom_en`, and `fetch_done` rises in the third cycle after acceptance with `fetch_code` equal to the ROM byte.
- R4: With `ext_strap` = 1, address 0x0FFF is internal and address 0x1000 and above are external.
- R5: An external fetch takes four cycles after acceptance:
  - cycle 1: `ale` = 1, `p0_oe` = 1, `p0_out` = low address byte;
  - cycles 2–3: `psen_n` = 0 and `p0_oe` = 0;
  - the code byte on `p0_in` is sampled at the end of cycle 3;
  - cycle 4: `psen_n` = 1, port 0 stays released, and `fetch_done` = 1.

  `p2_oe` = 1 with `p2_out` = high address byte in cycles 1–3.
- R6: `fetch_mode` selects the source of the fetch address:
  - 2'b00 (sequential) uses the address of the previous fetch plus one, wrapping from 0xFFFF to 0x0000;
  - 2'b01 (jump) uses `fetch_target`.
- R7: `fetch_mode` 2'b10 (vector) fetches from 0x0003 + 8 × `vec_idx` (0x0003, 0x000B, 0x0013, 0x001B, ...).
- R8: A data read takes four cycles after acceptance:
  - cycle 1: `ale` = 1 with the low address on port 0;
  - cycles 2–3: `rd_n` = 0 with port 0 released;
  - cycle 4: `dat_done` = 1 with `dat_rdata` equal to the byte on `p0_in` at the end of cycle 3.

  With `dat_wide` = 0, `p2_oe` stays 0 throughout.
- R9: With `dat_wide` = 1, `p2_oe` = 1 and `p2_out` = high address byte in cycles 1–3 of a data access.
- R10: A data write holds `wr_n` = 0 in cycles 2–3 with `p0_oe` = 1 and `p0_out` = write byte, while `rd_n` stays 1.
- R11: When `fetch_req` and `dat_req` are both presented in one ready cycle, the fetch is served first. The data access is accepted in the idle cycle after `fetch_done`, so for an external fetch its `ale` appears in cycle 6.
- R12: `psen_n` is never 0 during a data access, `rd_n`/`wr_n` are never 0 during a fetch, and at most one of the three strobes is low at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_strap | input | 1 | 1: low addresses come from internal ROM; 0: everything external |
| fetch_req | input | 1 | Fetch request, taken when `fetch_ready` is 1 |
| fetch_mode | input | 2 | 00 sequential, 01 jump, 10 vector |
| fetch_target | input | 16 | Jump address |
| vec_idx | input | 3 | Interrupt vector index |
| fetch_ready | output | 1 | Sequencer can take a new request |
| fetch_done | output | 1 | Code byte valid this cycle |
| fetch_addr | output | 16 | Address of the completed fetch |
| fetch_code | output | 8 | Fetched code byte |
| fetch_ext | output | 1 | Completed fetch used the external bus |
| dat_req | input | 1 | External data request |
| dat_write | input | 1 | 1 write, 0 read |
| dat_wide | input | 1 | 1: 16-bit address on both ports; 0: 8-bit address |
| dat_addr | input | 16 | Data address |
| dat_wdata | input | 8 | Write byte |
| dat_done | output | 1 | Data access complete this cycle |
| dat_rdata | output | 8 | Read byte |
| rom_en | output | 1 | Internal ROM read enable |
| rom_addr | output | 16 | Internal ROM address |
| rom_data | input | 8 | ROM byte, one cycle after `rom_en` |
| ale | output | 1 | Address latch strobe |
| psen_n | output | 1 | External code read strobe, active low |
| rd_n | output | 1 | External data read strobe, active low |
| wr_n | output | 1 | External data write strobe, active low |
| p0_out | output | 8 | Port 0 drive value (low address / write data) |
| p0_oe | output | 1 | Port 0 drive enable |
| p0_in | input | 8 | Port 0 input (code / read data) |
| p2_out | output | 8 | Port 2 drive value (high address) |
| p2_oe | output | 1 | Port 2 drive enable |

## Verification
Latency is counted from the clock edge that accepts a request:
- an internal fetch completes in cycle 3;
- an external fetch or data access completes in cycle 4;
- a data access queued behind a fetch shows its address strobe two cycles after that fetch completes.

The bench raises a request at a falling edge and drops it at the next one. It then samples every port at each falling edge and compares the cycle number against these counts. The address strobe, the strobe pair and the completion cycle are checked on exactly the expected cycle numbers. Strobe activity over a whole transfer is tallied by edge counters, so a strobe that should stay quiet is seen never to move.

// File: rtl/prog_bus_pkg.sv
// Shared encodings for the program fetch bus sequencer.
package prog_bus_pkg;
    // Source of the next fetch address.
    typedef enum logic [1:0] {
        FM_SEQ  = 2'b00,
        FM_JUMP = 2'b01,
        FM_VEC  = 2'b10
    } fetch_mode_e;

    // Bus sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROM,
        ST_ROMW,
        ST_ADDR,
        ST_STRB,
        ST_DONE
    } bus_state_e;

    // Kind of transfer in flight.
    typedef enum logic [1:0] {
        OP_FETCH,
        OP_READ,
        OP_WRITE
    } bus_op_e;
endpackage

// File: rtl/prog_bus_route.sv
// Fetch address selection and internal/external routing.
// Holds the program counter (reset 0). Picks the sequential, jump or
// vector address. Decides whether that address lies in internal ROM.
// Assumes take is asserted only when the sequencer accepts a fetch.
module prog_bus_route #(
    parameter int AW        = 16,
    parameter int IDX_W     = 3,
    parameter int ROM_BYTES = 4096,
    parameter int VEC_BASE  = 3,
    parameter int VEC_STEP  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ext_strap,
    input  logic [1:0]           mode,
    input  logic [AW-1:0]        jump_addr,
    input  logic [IDX_W-1:0]     vec_idx,
    input  logic                 take,
    output logic [AW-1:0]        sel_addr,
    output logic                 sel_int
);
    import prog_bus_pkg::*;

    localparam logic [AW-1:0] VB_C = AW'(VEC_BASE);
    localparam logic [AW-1:0] VS_C = AW'(VEC_STEP);

    logic [AW-1:0] pc_q;

    // Choose the address of the fetch being requested.
    always_comb begin
        case (fetch_mode_e'(mode))
            FM_JUMP: sel_addr = jump_addr;
            FM_VEC:  sel_addr = VB_C + VS_C * AW'(vec_idx);
            default: sel_addr = pc_q;
        endcase
    end

    // Internal decode: absent ROM means every fetch goes outside.
    generate
        if (ROM_BYTES == 0) begin : g_no_rom
            assign sel_int = 1'b0;
        end else begin : g_rom
            localparam logic [AW:0] LIMIT_C = (AW+1)'(ROM_BYTES);
            assign sel_int = ext_strap && ({1'b0, sel_addr} < LIMIT_C);
        end
    endgenerate

    // Program counter: next sequential address after each accepted fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= '0;
        else if (take)
            pc_q <= sel_addr + AW'(1);
    end
endmodule

// File: rtl/prog_bus_slot.sv
// Single-entry holding slot for a data request that collided with a fetch.
// Assumes load and clear are never asserted together.
module prog_bus_slot #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          clear,
    input  logic          in_write,
    input  logic          in_wide,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_wdata,
    output logic          pend,
    output logic          p_write,
    output logic          p_wide,
    output logic [AW-1:0] p_addr,
    output logic [DW-1:0] p_wdata
);
    // Valid flag of the slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (load)
            pend <= 1'b1;
        else if (clear)
            pend <= 1'b0;
    end

    // Request fields captured with the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_write <= 1'b0;
            p_wide  <= 1'b0;
            p_addr  <= '0;
            p_wdata <= '0;
        end else if (load) begin
            p_write <= in_write;
            p_wide  <= in_wide;
            p_addr  <= in_addr;
            p_wdata <= in_wdata;
        end
    end
endmodule

// File: rtl/prog_bus_ctl.sv
// Bus cycle sequencer. Runs one transfer at a time:
//   - internal fetch: ROM, ROMW, DONE;
//   - external fetch or data move: ADDR, STRB x STROBE_CYCLES, DONE.
// DONE also serves as the bus turnaround with port 0 released.
// Assumes start_fetch and start_data are only asserted in idle, never together.
module prog_bus_ctl #(
    parameter int AW            = 16,
    parameter int DW            = 8,
    parameter int STROBE_CYCLES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_fetch,
    input  logic [AW-1:0] f_addr,
    input  logic          f_int,
    input  logic          start_data,
    input  logic          d_write,
    input  logic          d_wide,
    input  logic [AW-1:0] d_addr,
    input  logic [DW-1:0] d_wdata,
    input  logic [DW-1:0] rom_data,
    input  logic [DW-1:0] p0_in,
    output logic          idle,
    output logic          rom_en,
    output logic [AW-1:0] rom_addr,
    output logic          ale,
    output logic          psen_n,
    output logic          rd_n,
    output logic          wr_n,
    output logic [DW-1:0] p0_out,
    output logic          p0_oe,
    output logic [AW-DW-1:0] p2_out,
    output logic          p2_oe,
    output logic          f_done,
    output logic          f_ext,
    output logic [AW-1:0] f_addr_q,
    output logic [DW-1:0] cap_q,
    output logic          d_done
);
    import prog_bus_pkg::*;

    localparam int CW = $clog2(STROBE_CYCLES + 1);
    localparam logic [CW-1:0] LAST_C = CW'(STROBE_CYCLES - 1);

    bus_state_e    state_q;
    bus_op_e       op_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          wide_q;
    logic          int_q;
    logic [CW-1:0] cnt_q;

    // State machine and transfer context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_FETCH;
            addr_q  <= '0;
            wdata_q <= '0;
            wide_q  <= 1'b0;
            int_q   <= 1'b0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (start_fetch) begin
                        op_q    <= OP_FETCH;
                        addr_q  <= f_addr;
                        int_q   <= f_int;
                        wide_q  <= 1'b1;
                        state_q <= f_int ? ST_ROM : ST_ADDR;
                    end else if (start_data) begin
                        op_q    <= d_write ? OP_WRITE : OP_READ;
                        addr_q  <= d_addr;
                        wdata_q <= d_wdata;
                        wide_q  <= d_wide;
                        int_q   <= 1'b0;
                        state_q <= ST_ADDR;
                    end
                end
                ST_ROM:  state_q <= ST_ROMW;
                ST_ROMW: state_q <= ST_DONE;
                ST_ADDR: state_q <= ST_STRB;
                ST_STRB: begin
                    if (cnt_q == LAST_C) begin
                        cnt_q   <= '0;
                        state_q <= ST_DONE;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Captured result byte: ROM data or port 0 at the last strobe cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cap_q <= '0;
        else if (state_q == ST_ROMW)
            cap_q <= rom_data;
        else if (state_q == ST_STRB && cnt_q == LAST_C && op_q != OP_WRITE)
            cap_q <= p0_in;
    end

    // Bus pin decode from the current state and operation.
    always_comb begin
        idle     = (state_q == ST_IDLE);
        rom_en   = (state_q == ST_ROM);
        rom_addr = addr_q;
        ale      = (state_q == ST_ADDR);
        psen_n   = !(state_q == ST_STRB && op_q == OP_FETCH);
        rd_n     = !(state_q == ST_STRB && op_q == OP_READ);
        wr_n     = !(state_q == ST_STRB && op_q == OP_WRITE);
        p0_oe    = (state_q == ST_ADDR) || (state_q == ST_STRB && op_q == OP_WRITE);
        p0_out   = (state_q == ST_ADDR) ? addr_q[DW-1:0] :
                   (p0_oe ? wdata_q : '0);
        p2_oe    = (state_q == ST_ADDR || state_q == ST_STRB) && wide_q;
        p2_out   = p2_oe ? addr_q[AW-1:DW] : '0;
        f_done   = (state_q == ST_DONE) && (op_q == OP_FETCH);
        d_done   = (state_q == ST_DONE) && (op_q != OP_FETCH);
        f_ext    = !int_q;
        f_addr_q = addr_q;
    end
endmodule

// File: rtl/prog_bus_seq.sv
// Program fetch bus sequencer top.
// Arbitrates fetch and data requests (fetch first on a tie, data parked in
// a slot). Routes fetches by strap and ROM size. Drives the multiplexed bus.
// Assumes requests are offered only while fetch_ready is high.
module prog_bus_seq #(
    parameter int AW            = 16,
    parameter int DW            = 8,
    parameter int IDX_W         = 3,
    parameter int ROM_BYTES     = 4096,
    parameter int VEC_BASE      = 3,
    parameter int VEC_STEP      = 8,
    parameter int STROBE_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_strap,
    input  logic             fetch_req,
    input  logic [1:0]       fetch_mode,
    input  logic [AW-1:0]    fetch_target,
    input  logic [IDX_W-1:0] vec_idx,
    output logic             fetch_ready,
    output logic             fetch_done,
    output logic [AW-1:0]    fetch_addr,
    output logic [DW-1:0]    fetch_code,
    output logic             fetch_ext,
    input  logic             dat_req,
    input  logic             dat_write,
    input  logic             dat_wide,
    input  logic [AW-1:0]    dat_addr,
    input  logic [DW-1:0]    dat_wdata,
    output logic             dat_done,
    output logic [DW-1:0]    dat_rdata,
    output logic             rom_en,
    output logic [AW-1:0]    rom_addr,
    input  logic [DW-1:0]    rom_data,
    output logic             ale,
    output logic             psen_n,
    output logic             rd_n,
    output logic             wr_n,
    output logic [DW-1:0]    p0_out,
    output logic             p0_oe,
    input  logic [DW-1:0]    p0_in,
    output logic [AW-DW-1:0] p2_out,
    output logic             p2_oe
);
    logic          idle;
    logic          pend;
    logic          p_write, p_wide;
    logic [AW-1:0] p_addr;
    logic [DW-1:0] p_wdata;
    logic          take_fetch, take_data, park_data;
    logic [AW-1:0] sel_addr;
    logic          sel_int;
    logic          s_write, s_wide;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_wdata;
    logic [DW-1:0] cap;

    // Request arbitration: parked data first, then fetch, then new data.
    always_comb begin
        fetch_ready = idle && !pend;
        take_fetch  = fetch_ready && fetch_req;
        park_data   = fetch_ready && fetch_req && dat_req;
        take_data   = idle && (pend || (fetch_ready && dat_req && !fetch_req));
        s_write     = pend ? p_write : dat_write;
        s_wide      = pend ? p_wide  : dat_wide;
        s_addr      = pend ? p_addr  : dat_addr;
        s_wdata     = pend ? p_wdata : dat_wdata;
    end

    prog_bus_route #(
        .AW(AW), .IDX_W(IDX_W), .ROM_BYTES(ROM_BYTES),
        .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
    ) u_route (
        .clk(clk), .rst_n(rst_n), .ext_strap(ext_strap),
        .mode(fetch_mode), .jump_addr(fetch_target), .vec_idx(vec_idx),
        .take(take_fetch), .sel_addr(sel_addr), .sel_int(sel_int)
    );

    prog_bus_slot #(.AW(AW), .DW(DW)) u_slot (
        .clk(clk), .rst_n(rst_n), .load(park_data), .clear(idle && pend),
        .in_write(dat_write), .in_wide(dat_wide), .in_addr(dat_addr),
        .in_wdata(dat_wdata), .pend(pend), .p_write(p_write),
        .p_wide(p_wide), .p_addr(p_addr), .p_wdata(p_wdata)
    );

    prog_bus_ctl #(.AW(AW), .DW(DW), .STROBE_CYCLES(STROBE_CYCLES)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .start_fetch(take_fetch), .f_addr(sel_addr), .f_int(sel_int),
        .start_data(take_data), .d_write(s_write), .d_wide(s_wide),
        .d_addr(s_addr), .d_wdata(s_wdata),
        .rom_data(rom_data), .p0_in(p0_in),
        .idle(idle), .rom_en(rom_en), .rom_addr(rom_addr),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out), .p2_oe(p2_oe),
        .f_done(fetch_done), .f_ext(fetch_ext), .f_addr_q(fetch_addr),
        .cap_q(cap), .d_done(dat_done)
    );

    // Both completion paths report the same captured byte.
    assign fetch_code = cap;
    assign dat_rdata  = cap;
endmodule

// File: rtl/prog_bus_seq_chk.sv
// Protocol checker for the bus pins of prog_bus_seq.
module prog_bus_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic rom_en,
    input logic ale,
    input logic psen_n,
    input logic rd_n,
    input logic wr_n,
    input logic p0_oe
);
    // R3: ROM access and external code strobe never overlap
    assert_rom_no_psen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rom_en |-> psen_n);

    // R12: strobes are mutually exclusive
    assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);

    // R5: address phase drives port 0
    assert_ale_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> p0_oe);

    // R5: code strobe begins right after the address strobe
    assert_psen_after_ale_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(psen_n) |-> $past(ale));

    // R5: port 0 released while code is returned
    assert_psen_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !psen_n |-> !p0_oe);

    // R8: port 0 released during a data read
    assert_rd_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !p0_oe);

    // R10: port 0 driven during a data write
    assert_wr_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> p0_oe);
endmodule

bind prog_bus_seq prog_bus_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rom_en(rom_en), .ale(ale), .psen_n(psen_n),
    .rd_n(rd_n), .wr_n(wr_n), .p0_oe(p0_oe)
);

// File: tb/prog_bus_seq_tb.sv
module prog_bus_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_strap = 1'b1;
    logic        fetch_req = 1'b0;
    logic [1:0]  fetch_mode = 2'b00;
    logic [15:0] fetch_target = '0;
    logic [2:0]  vec_idx = '0;
    logic        fetch_ready, fetch_done, fetch_ext;
    logic [15:0] fetch_addr;
    logic [7:0]  fetch_code;
    logic        dat_req = 1'b0, dat_write = 1'b0, dat_wide = 1'b0;
    logic [15:0] dat_addr = '0;
    logic [7:0]  dat_wdata = '0;
    logic        dat_done;
    logic [7:0]  dat_rdata;
    logic        rom_en;
    logic [15:0] rom_addr;
    logic [7:0]  rom_data;
    logic        ale, psen_n, rd_n, wr_n, p0_oe, p2_oe;
    logic [7:0]  p0_out, p0_in, p2_out;

    int checks = 0;
    int errors = 0;
    int psen_cnt = 0, rom_cnt = 0, rdwr_cnt = 0;
    logic [7:0] lat_lo = '0;
    logic [7:0] xmem [256];

    always #5 clk = ~clk;

    prog_bus_seq u_dut (
        .clk(clk), .rst_n(rst_n), .ext_strap(ext_strap),
        .fetch_req(fetch_req), .fetch_mode(fetch_mode),
        .fetch_target(fetch_target), .vec_idx(vec_idx),
        .fetch_ready(fetch_ready), .fetch_done(fetch_done),
        .fetch_addr(fetch_addr), .fetch_code(fetch_code), .fetch_ext(fetch_ext),
        .dat_req(dat_req), .dat_write(dat_write), .dat_wide(dat_wide),
        .dat_addr(dat_addr), .dat_wdata(dat_wdata), .dat_done(dat_done),
        .dat_rdata(dat_rdata), .rom_en(rom_en), .rom_addr(rom_addr),
        .rom_data(rom_data), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
        .wr_n(wr_n), .p0_out(p0_out), .p0_oe(p0_oe), .p0_in(p0_in),
        .p2_out(p2_out), .p2_oe(p2_oe)
    );

    function automatic logic [7:0] rom_code(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction
    function automatic logic [7:0] ext_code(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hC3;
    endfunction

    // ROM model, one-cycle latency; external memory model on the bus.
    always_ff @(posedge clk) begin
        if (rom_en) rom_data <= rom_code(rom_addr);
        if (ale) lat_lo <= p0_out;
        if (!wr_n) xmem[lat_lo] <= p0_out;
        if (!psen_n) psen_cnt <= psen_cnt + 1;
        if (rom_en) rom_cnt <= rom_cnt + 1;
        if (!rd_n || !wr_n) rdwr_cnt <= rdwr_cnt + 1;
    end
    assign p0_in = !psen_n ? ext_code({p2_out, lat_lo}) :
                   (!rd_n ? xmem[lat_lo] : 8'h00);

    task automatic chk(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    // Vector rows: {strap, mode, idx, target, exp_addr, exp_ext}
    localparam int NV = 13;
    localparam logic [38:0] VECS [NV] = '{
        {1'b1, 2'b00, 3'd0, 16'h0000, 16'h0000, 1'b0},  // R1 R3
        {1'b1, 2'b00, 3'd0, 16'h0000, 16'h0001, 1'b0},  // R6
        {1'b1, 2'b01, 3'd0, 16'h0FFF, 16'h0FFF, 1'b0},  // R4
        {1'b1, 2'b00, 3'd0, 16'h0000, 16'h1000, 1'b1},  // R4 R6
        {1'b1, 2'b01, 3'd0, 16'h1234, 16'h1234, 1'b1},
        {1'b0, 2'b01, 3'd0, 16'h0010, 16'h0010, 1'b1},  // R2
        {1'b0, 2'b00, 3'd0, 16'h0000, 16'h0011, 1'b1},  // R2
        {1'b1, 2'b10, 3'd0, 16'h0000, 16'h0003, 1'b0},  // R7
        {1'b1, 2'b10, 3'd1, 16'h0000, 16'h000B, 1'b0},  // R7
        {1'b1, 2'b10, 3'd3, 16'h0000, 16'h001B, 1'b0},  // R7
        {1'b1, 2'b10, 3'd7, 16'h0000, 16'h003B, 1'b0},  // R7
        {1'b1, 2'b01, 3'd0, 16'hFFFF, 16'hFFFF, 1'b1},
        {1'b1, 2'b00, 3'd0, 16'h0000, 16'h0000, 1'b0}   // R6 wrap
    };

    task automatic run_fetch(input logic [38:0] v, input int row);
        int n;
        int p0, r0, d0;
        logic [15:0] ea;
        logic ee;
        ea = v[16:1];
        ee = v[0];
        @(negedge clk);
        ext_strap = v[38]; fetch_mode = v[37:36]; vec_idx = v[35:33];
        fetch_target = v[32:17];
        p0 = psen_cnt; r0 = rom_cnt; d0 = rdwr_cnt;
        fetch_req = 1'b1;
        @(negedge clk);
        fetch_req = 1'b0;
        n = 1;
        while (!fetch_done && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk(fetch_addr == ea, $sformatf("R6/R7 row %0d address", row), fetch_addr, ea);
        chk(fetch_ext == ee, $sformatf("R2/R4 row %0d routing", row), fetch_ext, ee);
        chk(n == (ee ? 4 : 3), $sformatf("R3/R5 row %0d latency", row), n, ee ? 4 : 3);
        chk(fetch_code == (ee ? ext_code(ea) : rom_code(ea)),
            $sformatf("R3 row %0d code", row), fetch_code,
            ee ? ext_code(ea) : rom_code(ea));
        chk((psen_cnt - p0) == (ee ? 2 : 0), $sformatf("R3 row %0d psen cycles", row),
            psen_cnt - p0, ee ? 2 : 0);
        chk((rom_cnt - r0) == (ee ? 0 : 1), $sformatf("R3 row %0d rom reads", row),
            rom_cnt - r0, ee ? 0 : 1);
        chk(rdwr_cnt == d0, "R12 no rd/wr in fetch", rdwr_cnt - d0, 0);
    endtask

    // Data access with per-cycle checks (R8, R9, R10, R12).
    task automatic run_data(input logic wr, input logic wide, input logic [15:0] a,
                            input logic [7:0] wd, input logic [7:0] exp_rd);
        int p0;
        p0 = psen_cnt;
        @(negedge clk);
        dat_req = 1'b1; dat_write = wr; dat_wide = wide; dat_addr = a; dat_wdata = wd;
        @(negedge clk);
        dat_req = 1'b0;
        chk(ale && p0_oe && p0_out == a[7:0], "R8 address phase", p0_out, a[7:0]);
        chk(p2_oe == wide, "R8/R9 port2 enable c1", p2_oe, wide);
        if (wide) chk(p2_out == a[15:8], "R9 high byte c1", p2_out, a[15:8]);
        for (int c = 2; c <= 3; c++) begin
            @(negedge clk);
            chk(rd_n == wr && wr_n == !wr, $sformatf("R8/R10 strobe c%0d", c),
                {rd_n, wr_n}, {wr, !wr});
            chk(p0_oe == wr, $sformatf("R8/R10 port0 dir c%0d", c), p0_oe, wr);
            if (wr) chk(p0_out == wd, "R10 write byte", p0_out, wd);
            chk(p2_oe == wide, $sformatf("R9 port2 enable c%0d", c), p2_oe, wide);
        end
        @(negedge clk);
        chk(dat_done, "R8 done cycle 4", dat_done, 1);
        chk(!p0_oe && rd_n && wr_n, "R8 turnaround", p0_oe, 0);
        if (!wr) chk(dat_rdata == exp_rd, "R8 read data", dat_rdata, exp_rd);
        chk(psen_cnt == p0, "R12 no psen in data", psen_cnt - p0, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) xmem[i] = 8'(i) ^ 8'h96;
        repeat (3) @(negedge clk);
        // R1: idle state after reset
        chk(psen_n && rd_n && wr_n && !ale && !p0_oe && !p2_oe && !rom_en,
            "R1 idle pins", {psen_n, rd_n, wr_n, ale, p0_oe, p2_oe, rom_en}, 7'b1110000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fetch_ready, "R1 ready", fetch_ready, 1);

        for (int i = 0; i < NV; i++) run_fetch(VECS[i], i);

        // R5: external fetch cycle by cycle
        @(negedge clk);
        ext_strap = 1'b1; fetch_mode = 2'b01; fetch_target = 16'hA55A; fetch_req = 1'b1;
        @(negedge clk);
        fetch_req = 1'b0;
        chk(ale && p0_oe && p0_out == 8'h5A && psen_n, "R5 c1 address", p0_out, 8'h5A);
        chk(p2_oe && p2_out == 8'hA5, "R5 c1 high byte", p2_out, 8'hA5);
        for (int c = 2; c <= 3; c++) begin
            @(negedge clk);
            chk(!psen_n && !p0_oe && !ale, $sformatf("R5 c%0d strobe", c),
                {psen_n, p0_oe, ale}, 3'b000);
            chk(p2_oe && p2_out == 8'hA5, $sformatf("R5 c%0d high byte", c), p2_out, 8'hA5);
        end
        @(negedge clk);
        chk(fetch_done && psen_n && !p0_oe, "R5 c4 done", fetch_done, 1);
        chk(fetch_code == ext_code(16'hA55A), "R5 code", fetch_code, ext_code(16'hA55A));

        run_data(1'b0, 1'b0, 16'h0040, 8'h00, 8'h40 ^ 8'h96);  // R8 narrow read
        run_data(1'b0, 1'b1, 16'h7E21, 8'h00, 8'h21 ^ 8'h96);  // R9 wide read
        run_data(1'b1, 1'b0, 16'h0077, 8'hE4, 8'h00);          // R10 write
        run_data(1'b0, 1'b0, 16'h0077, 8'h00, 8'hE4);          // R10 read back

        // R11: simultaneous fetch and data request
        begin
            int n;
            int fd, da, dd;
            fd = 0; da = 0; dd = 0;
            @(negedge clk);
            fetch_mode = 2'b01; fetch_target = 16'h2000; fetch_req = 1'b1;
            dat_req = 1'b1; dat_write = 1'b0; dat_wide = 1'b0; dat_addr = 16'h0033;
            for (n = 1; n <= 10; n++) begin
                @(negedge clk);
                fetch_req = 1'b0; dat_req = 1'b0;
                if (fetch_done && fd == 0) fd = n;
                if (ale && da == 0 && n > 1) da = n;
                if (dat_done && dd == 0) dd = n;
            end
            chk(fd == 4, "R11 fetch first", fd, 4);
            chk(da == 6, "R11 data ale cycle", da, 6);
            chk(dd == 9, "R11 data done", dd, 9);
            chk(dat_rdata == (8'h33 ^ 8'h96), "R11 data value", dat_rdata, 8'h33 ^ 8'h96);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1 act=%0d exp=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule